// File: doc/BRIEF.md
# Four-Direction Parity Encoder

The block turns a 64-bit data word into a 114-bit protected codeword. It treats the word as an 8x8 bit array and adds even-parity check bits over four families of lines: rows, columns, rising (slash) diagonals and falling (backslash) diagonals. The diagonal lines differ in length, from a one-bit corner line to an eight-bit middle line. Each family also gets one more check bit, which is the parity of that family's own line parities.

All four families are computed side by side in one combinational stage. A single register stage captures the data together with its check bits when `in_valid` is high. The registered codeword is then written to storage. When `in_valid` is low the register keeps its value.

Top module: `mdp_encoder`

## Requirements
- R1: While `rst` is sampled high on a rising edge, `out_valid` and every bit of `out_code` become 0 at that edge.
- R2: After a capture, `out_code[63:0]` equals the captured data word, where data bit `8*r+c` is array row r, column c.
- R3: `out_code[64+r]` (r = 0..7) is the XOR of the eight data bits of row r.
- R4: `out_code[72+c]` (c = 0..7) is the XOR of the eight data bits of column c.
- R5: `out_code[80+k]` (k = 0..14) is the XOR of all data bits with r+c = k.
- R6: `out_code[95+k]` (k = 0..14) is the XOR of all data bits with r-c+7 = k.
- R7: Bits 110, 111, 112 and 113 hold the XOR of the row, column, slash and backslash parity bits, in that order. All four are therefore equal to the parity of the whole data word.
- R8: The corner diagonals hold one bit each: slash line 0 covers only data bit 0, slash line 14 only bit 63, backslash line 0 only bit 7, and backslash line 14 only bit 56.
- R9: A word presented with `in_valid` high at a rising edge appears on `out_code`, with `out_valid` high, right after that edge. `out_valid` is low after any edge at which `in_valid` was low.
- R10: At an edge where `in_valid` is low, `out_code` keeps its previous value whatever `in_data` carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Data word on `in_data` is to be encoded |
| in_data | input | 64 | Data word, bit 8*r+c at row r, column c |
| out_valid | output | 1 | `out_code` was loaded at the last edge |
| out_code | output | 114 | Data plus 50 check bits |

## Verification
The corner diagonals are the most likely place for an index mistake. A design that got the slash or backslash numbering wrong, for example by mirroring the columns, would put a lone corner bit on the wrong line of the 15, and single-bit words are applied at all four corners to catch this. Dense and patterned words (all ones, alternating bits, a counting pattern) catch a line that drops or repeats a member, because such a line has the wrong parity on at least one of these words. The per-direction extra bits are compared against the word's overall parity, which exposes a design that takes them from the wrong family or the wrong slice. Idle cycles with changing `in_data` show whether a design loads the register without the strobe or lets `out_valid` stay high.

// File: rtl/mdp_pkg.sv
package mdp_pkg;

  typedef enum logic [1:0] {
    DIR_ROW   = 2'd0,
    DIR_COL   = 2'd1,
    DIR_SLASH = 2'd2,
    DIR_BACK  = 2'd3
  } dir_e;

  // number of parity lines a direction has on a dim x dim array
  function automatic int lines_for(dir_e dir, int dim);
    return (dir == DIR_ROW || dir == DIR_COL) ? dim : 2 * dim - 1;
  endfunction

  // does array cell (r,c) lie on line k of direction dir
  function automatic bit on_line(dir_e dir, int k, int r, int c, int dim);
    case (dir)
      DIR_ROW:   return r == k;
      DIR_COL:   return c == k;
      DIR_SLASH: return (r + c) == k;
      default:   return (r - c + dim - 1) == k;
    endcase
  endfunction

  // total codeword width: data, rows, cols, two diagonal sets, four extras
  function automatic int code_width(int dim);
    return dim * dim + 2 * dim + 2 * (2 * dim - 1) + 4;
  endfunction

endpackage

// File: rtl/mdp_line_parity.sv
module mdp_line_parity
  import mdp_pkg::*;
#(
  parameter int   DIM = 8,
  parameter dir_e DIR = DIR_ROW,
  localparam int  NL  = lines_for(DIR, DIM),
  localparam int  DW  = DIM * DIM
) (
  input  logic [DW-1:0] data,
  output logic [NL-1:0] lines,
  output logic          extra
);

  // one XOR reduction per line, membership picked by the package predicate
  for (genvar k = 0; k < NL; k++) begin : g_line
    logic acc;
    always_comb begin
      acc = 1'b0;
      for (int r = 0; r < DIM; r++) begin
        for (int c = 0; c < DIM; c++) begin
          if (on_line(DIR, k, r, c, DIM)) acc = acc ^ data[r*DIM+c];
        end
      end
    end
    assign lines[k] = acc;
  end

  // parity over this direction's own parity bits
  assign extra = ^lines;

endmodule

// File: rtl/mdp_encode_core.sv
module mdp_encode_core
  import mdp_pkg::*;
#(
  parameter int  DIM = 8,
  localparam int DW  = DIM * DIM,
  localparam int NS  = 2 * DIM - 1,
  localparam int CW  = code_width(DIM)
) (
  input  logic [DW-1:0] data,
  output logic [CW-1:0] code,
  output logic [3:0]    extras
);

  logic [DIM-1:0] row_par, col_par;
  logic [NS-1:0]  sl_par, bk_par;

  mdp_line_parity #(.DIM(DIM), .DIR(DIR_ROW)) u_row (
    .data(data), .lines(row_par), .extra(extras[0]));
  mdp_line_parity #(.DIM(DIM), .DIR(DIR_COL)) u_col (
    .data(data), .lines(col_par), .extra(extras[1]));
  mdp_line_parity #(.DIM(DIM), .DIR(DIR_SLASH)) u_sl (
    .data(data), .lines(sl_par), .extra(extras[2]));
  mdp_line_parity #(.DIM(DIM), .DIR(DIR_BACK)) u_bk (
    .data(data), .lines(bk_par), .extra(extras[3]));

  assign code = {extras, bk_par, sl_par, col_par, row_par, data};

endmodule

// File: rtl/mdp_encoder.sv
module mdp_encoder
  import mdp_pkg::*;
#(
  parameter int  DIM = 8,
  localparam int DW  = DIM * DIM,
  localparam int NS  = 2 * DIM - 1,
  localparam int CW  = code_width(DIM),
  localparam int OFS_H = DW,
  localparam int OFS_V = OFS_H + DIM,
  localparam int OFS_X = OFS_V + DIM + 2 * NS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic [CW-1:0] out_code
);

  logic [CW-1:0] enc_code;
  logic [3:0]    enc_extras;

  mdp_encode_core #(.DIM(DIM)) u_core (
    .data(in_data), .code(enc_code), .extras(enc_extras));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_code  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_code <= enc_code;
    end
  end

  // named views of the registered fields, for the checks below
  logic [DIM-1:0] q_rows, q_cols;
  logic [3:0]     q_extra;
  assign q_rows  = out_code[OFS_H +: DIM];
  assign q_cols  = out_code[OFS_V +: DIM];
  assign q_extra = out_code[OFS_X +: 4];

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r9_valid_drops: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_code));
  a_r2_data_captured: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_code[DW-1:0] == $past(in_data));
  a_r7_extras_agree: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (q_extra == 4'b0000 || q_extra == 4'b1111));
  a_r7_extra_is_word_parity: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> q_extra[0] == ^out_code[DW-1:0]);
  a_r4_rows_cols_balance: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (^q_rows) == (^q_cols));

endmodule

// File: tb/mdp_encoder_tb_top.sv
`timescale 1ns/1ps
module mdp_encoder_tb_top;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [63:0]  in_data = '0;
  logic         out_valid;
  logic [113:0] out_code;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  mdp_encoder dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_code(out_code));

  // stimulus words with the expected parity of the whole word
  localparam int NV = 8;
  localparam logic [63:0] VEC [NV] = '{
    64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF,
    64'h0000_0000_0000_0001, 64'h8000_0000_0000_0000,
    64'hAAAA_AAAA_AAAA_AAAA, 64'h0123_4567_89AB_CDEF,
    64'h0000_0000_0000_0007, 64'h8100_0000_0000_0081};
  localparam bit VEC_PAR [NV] = '{0, 0, 1, 1, 0, 0, 1, 0};

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // expected codeword, built by scattering each set bit onto its lines
  function automatic logic [113:0] model(logic [63:0] d);
    logic [7:0]  h = '0, v = '0;
    logic [14:0] s = '0, b = '0;
    for (int i = 0; i < 64; i++) begin
      if (d[i]) begin
        h[i/8] ^= 1'b1;
        v[i%8] ^= 1'b1;
        s[i/8 + i%8] ^= 1'b1;
        b[i/8 - i%8 + 7] ^= 1'b1;
      end
    end
    return {^b, ^s, ^v, ^h, b, s, v, h, d};
  endfunction

  task automatic load(logic [63:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 out_valid", 128'(out_valid), 128'(0));
    chk("R1 out_code", 128'(out_code), 128'(0));
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [113:0] e;
      load(VEC[i]);
      e = model(VEC[i]);
      chk("R9 valid", 128'(out_valid), 128'(1));
      chk("R2 data", 128'(out_code[63:0]), 128'(e[63:0]));
      chk("R3 rows", 128'(out_code[71:64]), 128'(e[71:64]));
      chk("R4 cols", 128'(out_code[79:72]), 128'(e[79:72]));
      chk("R5 slash", 128'(out_code[94:80]), 128'(e[94:80]));
      chk("R6 backslash", 128'(out_code[109:95]), 128'(e[109:95]));
      chk("R7 extras", 128'(out_code[113:110]), 128'(e[113:110]));
      chk("R7 word parity", 128'(out_code[110]), 128'(VEC_PAR[i]));
    end

    // R8: corner diagonals
    load(64'h1);
    chk("R8 slash0", 128'(out_code[80]), 128'(1));
    chk("R8 slash single", 128'($countones(out_code[94:80])), 128'(1));
    load(64'h1 << 63);
    chk("R8 slash14", 128'(out_code[94]), 128'(1));
    chk("R8 back single", 128'($countones(out_code[109:95])), 128'(1));
    load(64'h1 << 7);
    chk("R8 back0", 128'(out_code[95]), 128'(1));
    chk("R8 slash7", 128'(out_code[87]), 128'(1));
    load(64'h1 << 56);
    chk("R8 back14", 128'(out_code[109]), 128'(1));
    chk("R8 slash7 again", 128'(out_code[87]), 128'(1));

    // R9 / R10: idle cycles with changing data
    load(64'h0123_4567_89AB_CDEF);
    in_data = 64'hDEAD_BEEF_0000_FFFF;
    @(negedge clk);
    chk("R9 valid drops", 128'(out_valid), 128'(0));
    chk("R10 hold", 128'(out_code), 128'(model(64'h0123_4567_89AB_CDEF)));
    in_data = 64'h5555_5555_5555_5555;
    @(negedge clk);
    chk("R10 hold again", 128'(out_code), 128'(model(64'h0123_4567_89AB_CDEF)));

    // back-to-back words
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 64'hF0F0_F0F0_F0F0_F0F0;
    @(negedge clk);
    chk("R9 first of pair", 128'(out_code), 128'(model(64'hF0F0_F0F0_F0F0_F0F0)));
    in_data = 64'h0000_0000_0000_0100;
    @(negedge clk);
    chk("R9 second of pair", 128'(out_code), 128'(model(64'h100)));
    chk("R9 valid held", 128'(out_valid), 128'(1));
    in_valid = 1'b0;

    // R1: reset clears a loaded register
    rst = 1'b1;
    @(negedge clk);
    chk("R1 reset clears code", 128'(out_code), 128'(0));
    chk("R1 reset clears valid", 128'(out_valid), 128'(0));
    done = 1'b1;
  end

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
      end
      wait (done);
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule